// File: doc/BRIEF.md
# Nonvolatile Store/Recall Power Sequencer

This block is the power-sequencing controller for a nonvolatile SRAM that carries a shadow array. It watches a digital supply-good flag and write strobes from the SRAM port. When the supply comes up it runs a recall from the array. When the supply drops, or when an external agent pulls the active-low handshake line, it runs a store back to the array. All durations are counted in clock cycles and set by parameters.

A dirty flag records whether any write was accepted since the last completed nonvolatile cycle. A store is started only if that flag is set. When a store is triggered, writes stay open for a short grace window so that an SRAM cycle already in flight can finish. After that the port is inhibited for the whole store. The handshake line is driven low while a store is pending or running. It is then driven high for a short hold window and released to high impedance. A supply loss during a recall aborts the recall, and the controller returns to the powered-down state.

Top module: `nv_pwr_seq`

## Requirements
- R1: After reset the controller is powered-down. `rw_inhibit_o` is 1, `hs_oe_o` is 0, and no start or done pulse is asserted.
- R2: When `vgood_i` is 1 in the powered-down state, a recall begins. `recall_start_o` pulses in its first cycle and `recall_done_o` pulses in its last cycle, RECALL_CYC cycles later. The controller is then ready, and `rw_inhibit_o` is 0 while `vgood_i` is 1.
- R3: If `vgood_i` falls during a recall, the recall is aborted. No `recall_done_o` pulse and no store follow, and the controller is powered-down on the next cycle.
- R4: `rw_inhibit_o` is 1 during recall, during store, while powered-down, and whenever `vgood_i` is 0 outside the grace window. `wr_accept_o` equals `wr_strobe_i` when `rw_inhibit_o` is 0 and is 0 otherwise.
- R5: The dirty flag is set by any accepted write and cleared when a store or a recall completes. It decides whether a store is started (R6, R7, R8).
- R6: A fall of `vgood_i` while ready and dirty starts an automatic store. The store runs GRACE_CYC grace cycles, then STORE_CYC store cycles. `store_start_o` pulses in the first store cycle and `store_done_o` pulses in the last. The store completes even with the supply low.
- R7: `hs_req_ni` = 0 while ready with `vgood_i` = 1 starts a hardware store if the dirty flag is set. If the flag is clear, the request is ignored.
- R8: A fall of `vgood_i` while ready and clean takes the controller straight to powered-down. No store starts.
- R9: During the grace window `rw_inhibit_o` is 0 and writes are accepted, including with `vgood_i` low.
- R10: During grace and store, `hs_oe_o` is 1 and `hs_o` is 0. After the store, `hs_o` is 1 with `hs_oe_o` = 1 for HOLD_CYC cycles. Then `hs_oe_o` drops. The controller then goes to ready if `vgood_i` is 1, or to powered-down if it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vgood_i | input | 1 | Supply above switch threshold |
| wr_strobe_i | input | 1 | Write request from the SRAM port |
| hs_req_ni | input | 1 | Sensed level of the handshake line, low requests a store |
| rw_inhibit_o | output | 1 | Read/write inhibit to the SRAM port |
| wr_accept_o | output | 1 | Write strobe passed through when not inhibited |
| hs_o | output | 1 | Handshake line drive value |
| hs_oe_o | output | 1 | Handshake line drive enable |
| recall_start_o | output | 1 | Pulse in first recall cycle |
| recall_done_o | output | 1 | Pulse in last recall cycle |
| store_start_o | output | 1 | Pulse in first store cycle |
| store_done_o | output | 1 | Pulse in last store cycle |

## Verification
The bench first issues a hardware request right after a recall, while the array is clean. A design that ignored the dirty flag would start a store there. It then drops the supply after a store in which a grace-window write was captured. A design that did not clear the dirty flag on store completion would store a second time. A recall is cut short by a supply drop, which exposes any design that lets the recall finish or store on abort. The scoreboard checks the order of pulses and the exact recall and store lengths, which catches off-by-one timers. The handshake and inhibit levels are sampled in the grace, store and hold windows to catch an inhibit that asserts too early or a line that is released without the high drive.

// File: rtl/nv_pwr_seq_pkg.sv
package nv_pwr_seq_pkg;
  typedef enum logic [2:0] {
    S_OFF    = 3'd0,
    S_RECALL = 3'd1,
    S_READY  = 3'd2,
    S_GRACE  = 3'd3,
    S_STORE  = 3'd4,
    S_HOLD   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/nv_seq_timer.sv
module nv_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             first_o,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = limit_i - CNT_W'(1);
  assign first_o   = (cnt_q == '0);
  assign expired_o = (cnt_q == last);

  // saturates at the last cycle of the window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + CNT_W'(1);
  end

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q <= $past(last)));
endmodule

// File: rtl/nv_dirty_flag.sv
module nv_dirty_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dirty_o <= 1'b0;
    else if (set_i)  dirty_o <= 1'b1;
    else if (clr_i)  dirty_o <= 1'b0;
  end
endmodule

// File: rtl/nv_hs_drive.sv
module nv_hs_drive
  import nv_pwr_seq_pkg::*;
(
  input  seq_state_e state_i,
  output logic       hs_o,
  output logic       hs_oe_o
);
  always_comb begin
    hs_oe_o = 1'b0;
    hs_o    = 1'b1;
    unique case (state_i)
      S_GRACE, S_STORE: begin hs_oe_o = 1'b1; hs_o = 1'b0; end
      S_HOLD:           begin hs_oe_o = 1'b1; hs_o = 1'b1; end
      default:          ;
    endcase
  end
endmodule

// File: rtl/nv_pwr_seq.sv
module nv_pwr_seq
  import nv_pwr_seq_pkg::*;
#(
  parameter int RECALL_CYC = 20,
  parameter int STORE_CYC  = 16,
  parameter int GRACE_CYC  = 3,
  parameter int HOLD_CYC   = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vgood_i,
  input  logic wr_strobe_i,
  input  logic hs_req_ni,
  output logic rw_inhibit_o,
  output logic wr_accept_o,
  output logic hs_o,
  output logic hs_oe_o,
  output logic recall_start_o,
  output logic recall_done_o,
  output logic store_start_o,
  output logic store_done_o
);
  localparam int MAX_A = (RECALL_CYC > STORE_CYC) ? RECALL_CYC : STORE_CYC;
  localparam int MAX_B = (GRACE_CYC > HOLD_CYC) ? GRACE_CYC : HOLD_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] limit;
  logic             t_first, t_exp, dirty;

  always_comb begin
    unique case (state_q)
      S_RECALL: limit = CNT_W'(RECALL_CYC);
      S_GRACE:  limit = CNT_W'(GRACE_CYC);
      S_STORE:  limit = CNT_W'(STORE_CYC);
      S_HOLD:   limit = CNT_W'(HOLD_CYC);
      default:  limit = CNT_W'(1);
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:    if (vgood_i) state_d = S_RECALL;
      S_RECALL: if (!vgood_i) state_d = S_OFF;
                else if (t_exp) state_d = S_READY;
      S_READY:  if (!vgood_i) state_d = dirty ? S_GRACE : S_OFF;
                else if (!hs_req_ni && dirty) state_d = S_GRACE;
      S_GRACE:  if (t_exp) state_d = S_STORE;
      S_STORE:  if (t_exp) state_d = S_HOLD;
      S_HOLD:   if (t_exp) state_d = vgood_i ? S_READY : S_OFF;
      default:  state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_OFF;
    else         state_q <= state_d;
  end

  nv_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_d != state_q),
    .limit_i   (limit),
    .first_o   (t_first),
    .expired_o (t_exp)
  );

  always_comb begin
    unique case (state_q)
      S_GRACE:         rw_inhibit_o = 1'b0;
      S_READY, S_HOLD: rw_inhibit_o = !vgood_i;
      default:         rw_inhibit_o = 1'b1;
    endcase
  end

  assign wr_accept_o    = wr_strobe_i && !rw_inhibit_o;
  assign recall_start_o = (state_q == S_RECALL) && t_first;
  assign recall_done_o  = (state_q == S_RECALL) && t_exp && vgood_i;
  assign store_start_o  = (state_q == S_STORE) && t_first;
  assign store_done_o   = (state_q == S_STORE) && t_exp;

  nv_dirty_flag u_dirty (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (wr_accept_o),
    .clr_i   (store_done_o || recall_done_o),
    .dirty_o (dirty)
  );

  nv_hs_drive u_hs (
    .state_i (state_q),
    .hs_o    (hs_o),
    .hs_oe_o (hs_oe_o)
  );

  assert_dirty_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_accept_o |=> dirty);
  assert_dirty_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_done_o |=> !dirty);
  assert_clean_skip_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_READY && !vgood_i && !dirty) |=> (state_q == S_OFF && !store_start_o));
  assert_abort_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_RECALL && !vgood_i) |=> (state_q == S_OFF));
  assert_start_after_grace_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> ($past(state_q) == S_GRACE));
  assert_release_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_oe_o) |-> $past(hs_o));
  assert_no_accept_store_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_STORE || state_q == S_RECALL) |-> !wr_accept_o);
endmodule

// File: tb/nv_pwr_seq_bench.sv
module nv_pwr_seq_bench;
  localparam int RC = 20, SC = 16, GC = 3, HC = 4;
  localparam int EV_RS = 1, EV_RD = 2, EV_SS = 3, EV_SD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vgood = 1'b0, wr = 1'b0, hs_req_n = 1'b1;
  logic inh, acc, hs, hs_oe, rs, rd, ss, sd;
  int   tests = 0, fails = 0, cyc = 0, rs_cyc = 0, ss_cyc = 0;
  int   expq[$];
  bit   done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nv_pwr_seq #(.RECALL_CYC(RC), .STORE_CYC(SC), .GRACE_CYC(GC), .HOLD_CYC(HC)) u_nv_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .vgood_i(vgood), .wr_strobe_i(wr), .hs_req_ni(hs_req_n),
    .rw_inhibit_o(inh), .wr_accept_o(acc), .hs_o(hs), .hs_oe_o(hs_oe),
    .recall_start_o(rs), .recall_done_o(rd), .store_start_o(ss), .store_done_o(sd));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic see(input int ev, input string req);
    int e;
    if (expq.size() == 0) begin
      chk(req, ev, 0);
    end else begin
      e = expq.pop_front();
      chk(req, ev, e);
    end
  endtask

  // monitor: pops expected pulse events and checks window lengths
  always @(negedge clk) begin
    if (rst_n) begin
      if (rs) begin see(EV_RS, "R2 recall start"); rs_cyc = cyc; end
      if (rd) begin see(EV_RD, "R2 recall done"); chk("R2 recall length", cyc - rs_cyc, RC - 1); end
      if (ss) begin see(EV_SS, "R6 store start"); ss_cyc = cyc; end
      if (sd) begin see(EV_SD, "R6 store done"); chk("R6 store length", cyc - ss_cyc, SC - 1); end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 inhibit", int'(inh), 1);
    chk("R1 hs_oe", int'(hs_oe), 0);
    chk("R1 pulses", int'({rs, rd, ss, sd}), 0);

    // R2 power-up recall
    expq.push_back(EV_RS); expq.push_back(EV_RD);
    vgood = 1'b1;
    step(1);
    chk("R4 inhibit in recall", int'(inh), 1);
    wr = 1'b1; #1;
    chk("R4 write ignored in recall", int'(acc), 0);
    wr = 1'b0;
    step(RC);
    chk("R2 ready inhibit", int'(inh), 0);

    // R7 clean hardware request ignored
    hs_req_n = 1'b0;
    step(3);
    chk("R7 clean request no drive", int'(hs_oe), 0);
    chk("R7 clean request inhibit", int'(inh), 0);
    hs_req_n = 1'b1;

    // R4/R5 accepted write makes the array dirty
    wr = 1'b1; #1;
    chk("R4 write accepted when ready", int'(acc), 1);
    step(1);
    wr = 1'b0;

    // R7 hardware store
    expq.push_back(EV_SS); expq.push_back(EV_SD);
    hs_req_n = 1'b0;
    step(1);
    hs_req_n = 1'b1;
    chk("R10 hs_oe in grace", int'(hs_oe), 1);
    chk("R10 hs low in grace", int'(hs), 0);
    chk("R9 inhibit low in grace", int'(inh), 0);
    wr = 1'b1; #1;
    chk("R9 write accepted in grace", int'(acc), 1);
    step(1);
    wr = 1'b0;
    step(GC - 1);
    chk("R4 inhibit in store", int'(inh), 1);
    chk("R10 hs low in store", int'(hs), 0);
    chk("R10 hs_oe in store", int'(hs_oe), 1);
    step(SC);
    chk("R10 hold drive", int'(hs_oe), 1);
    chk("R10 hold high", int'(hs), 1);
    step(HC);
    chk("R10 released", int'(hs_oe), 0);
    chk("R10 back to ready", int'(inh), 0);

    // R8 clean supply loss (grace write was cleared by R5 store completion)
    vgood = 1'b0;
    step(1);
    chk("R8 inhibit powered-down", int'(inh), 1);
    chk("R8 no store drive", int'(hs_oe), 0);
    step(SC + 5);

    // R3 aborted recall
    expq.push_back(EV_RS);
    vgood = 1'b1;
    step(5);
    vgood = 1'b0;
    step(1);
    chk("R3 inhibit after abort", int'(inh), 1);
    chk("R3 no store after abort", int'(hs_oe), 0);
    step(RC + 2);

    // R6 automatic store on supply loss
    expq.push_back(EV_RS); expq.push_back(EV_RD);
    vgood = 1'b1;
    step(RC + 1);
    chk("R2 ready after second recall", int'(inh), 0);
    wr = 1'b1;
    step(1);
    wr = 1'b0;
    expq.push_back(EV_SS); expq.push_back(EV_SD);
    vgood = 1'b0;
    step(1);
    chk("R9 inhibit low in grace with supply low", int'(inh), 0);
    chk("R6 hs_oe in auto grace", int'(hs_oe), 1);
    step(GC);
    chk("R6 inhibit in auto store", int'(inh), 1);
    step(SC);
    chk("R10 auto hold high", int'(hs), 1);
    chk("R4 inhibit in hold supply low", int'(inh), 1);
    step(HC);
    chk("R10 auto released", int'(hs_oe), 0);
    chk("R10 powered-down after auto", int'(inh), 1);
    wr = 1'b1; #1;
    chk("R4 write ignored powered-down", int'(acc), 0);
    wr = 1'b0;
    step(3);
    chk("R2 all events seen", expq.size(), 0);
    finish_run();
  end
endmodule